// File: doc/BRIEF.md
# Sleep wake-up and watchdog reset supervisor

This block supervises a microcontroller that spends most of its time asleep. Once reset has been released and a start-up delay has passed, it produces a free-running wake-up square wave. Each wake-up cycle opens with a rising edge. The processor is expected to answer every cycle with a falling edge on the watchdog input. The first such edge ends the wake-up high phase early. If a whole cycle passes with no answer, the block pulls its active-low reset output low.

Reset is also held low for as long as an external power-good flag is deasserted. Once power is good again, reset is released after a fixed delay. All durations derive from one parameter `TICK` in clock cycles:

- reset pulse: `TICK`
- reset-release to first wake-up edge: `4*TICK`
- wake-up period: `8*TICK`, of which the first `4*TICK` are the high half

`pwrGood` is treated as a synchronous input. The watchdog input is asynchronous and is synchronized inside the block.

Top module: `wake_supervisor`

## Requirements
- R1: In a wake-up cycle without a watchdog falling edge during its high half, `wakeOut` is high for exactly 4*TICK cycles and the cycle lasts exactly 8*TICK cycles.
- R2: Rising edges and steady levels on `wdRaw` never pull `wakeOut` low and never count as a watchdog answer.
- R3: A high-to-low transition on `wdRaw` is acted on after a two-flop synchronizer. It drives `wakeOut` low at the second clock edge after the edge that first samples the low level. `wakeOut` then stays low until the next cycle starts.
- R4: Further watchdog falling edges in a cycle that has already been answered have no effect: the cycle still ends after 8*TICK cycles and the next one opens high.
- R5: If a wake-up cycle ends with no watchdog falling edge in it, `rstOutN` goes low at the cycle end for exactly TICK cycles and is then released, provided `pwrGood` stays high.
- R6: `rstOutN` is low from the first clock edge that samples `pwrGood` low, for as long as it stays low. It rises at the TICK-th clock edge that samples `pwrGood` high.
- R7: `wakeOut` is low in every cycle in which `rstOutN` is low.
- R8: After `rstOutN` rises, `wakeOut` stays low and rises at the 4*TICK-th clock edge that follows. The cycle count starts over from the beginning.
- R9: While `rstAsyncN` is low, `rstOutN` and `wakeOut` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstAsyncN | input | 1 | Asynchronous active-low power-on reset |
| pwrGood | input | 1 | Output voltage within regulation (synchronous) |
| wdRaw | input | 1 | Raw watchdog input from the processor |
| wakeOut | output | 1 | Wake-up square wave |
| rstOutN | output | 1 | Active-low reset to the processor |

## Verification
The bench first runs directed patterns:

- A single answer early in the high half measures the two-cycle synchronizer latency.
- A second edge in the same cycle shows that only the first answer counts.
- A held-low watchdog has no falling edge in the next cycle. This separates a level from an edge and forces the timeout reset, whose length is measured.

Random stretches then vary the watchdog toggle rate from silent to busy and insert short power-good dropouts. A cycle-level model compares every output sample. These stretches tell apart answers that land in the high half, in the low half, on the final cycle of a period, or during the reset and start-up delay, where they must be ignored.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    PH_RST = 2'd0,
    PH_DLY = 2'd1,
    PH_RUN = 2'd2
  } phase_e;

  typedef struct packed {
    logic clr;
    logic inc;
  } cnt_strobe_t;
endpackage

// File: rtl/sup_datapath.sv
module sup_datapath
  import sup_pkg::*;
#(
  parameter int TICK = 4
) (
  input  logic        clk,
  input  logic        rstAsyncN,
  input  logic        wdRaw,
  input  cnt_strobe_t strobe,
  output logic        wdFall,
  output logic        atRstEnd,
  output logic        atDlyEnd,
  output logic        atCycEnd,
  output logic        inHighHalf
);
  localparam int CYC = 8 * TICK;
  localparam int CW  = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] RST_LAST = CW'(TICK - 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(4 * TICK - 1);
  localparam logic [CW-1:0] CYC_LAST = CW'(CYC - 1);
  localparam logic [CW-1:0] HALF     = CW'(4 * TICK);

  logic [2:0]    wdPipe;
  logic [CW-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) wdPipe <= 3'b111;
    else            wdPipe <= {wdPipe[1:0], wdRaw};
  end

  assign wdFall = wdPipe[2] & ~wdPipe[1];

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN)      tickCnt <= '0;
    else if (strobe.clr) tickCnt <= '0;
    else if (strobe.inc) tickCnt <= tickCnt + 1'b1;
  end

  assign atRstEnd   = (tickCnt == RST_LAST);
  assign atDlyEnd   = (tickCnt == DLY_LAST);
  assign atCycEnd   = (tickCnt == CYC_LAST);
  assign inHighHalf = (tickCnt < HALF);
endmodule

// File: rtl/sup_control.sv
module sup_control
  import sup_pkg::*;
(
  input  logic        clk,
  input  logic        rstAsyncN,
  input  logic        pwrGood,
  input  logic        wdFall,
  input  logic        atRstEnd,
  input  logic        atDlyEnd,
  input  logic        atCycEnd,
  input  logic        inHighHalf,
  output cnt_strobe_t strobe,
  output logic        wakeOut,
  output logic        rstOutN
);
  phase_e phase, phaseNext;
  logic   answered, answeredNext;

  always_comb begin
    phaseNext    = phase;
    answeredNext = answered;
    strobe.clr   = 1'b0;
    strobe.inc   = 1'b1;
    if (!pwrGood) begin
      phaseNext    = PH_RST;
      answeredNext = 1'b0;
      strobe.clr   = 1'b1;
    end else begin
      unique case (phase)
        PH_RST: if (atRstEnd) begin
          phaseNext  = PH_DLY;
          strobe.clr = 1'b1;
        end
        PH_DLY: if (atDlyEnd) begin
          phaseNext    = PH_RUN;
          answeredNext = 1'b0;
          strobe.clr   = 1'b1;
        end
        PH_RUN: begin
          if (wdFall) answeredNext = 1'b1;
          if (atCycEnd) begin
            strobe.clr   = 1'b1;
            answeredNext = 1'b0;
            if (!(answered || wdFall)) phaseNext = PH_RST;
          end
        end
        default: begin
          phaseNext  = PH_RST;
          strobe.clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) begin
      phase    <= PH_RST;
      answered <= 1'b0;
    end else begin
      phase    <= phaseNext;
      answered <= answeredNext;
    end
  end

  assign rstOutN = (phase != PH_RST);
  assign wakeOut = (phase == PH_RUN) && inHighHalf && !answered;
endmodule

// File: rtl/wake_supervisor.sv
module wake_supervisor
  import sup_pkg::*;
#(
  parameter int TICK = 4
) (
  input  logic clk,
  input  logic rstAsyncN,
  input  logic pwrGood,
  input  logic wdRaw,
  output logic wakeOut,
  output logic rstOutN
);
  cnt_strobe_t strobe;
  logic wdFall, atRstEnd, atDlyEnd, atCycEnd, inHighHalf;

  sup_datapath #(.TICK(TICK)) u_dp (
    .clk(clk), .rstAsyncN(rstAsyncN), .wdRaw(wdRaw), .strobe(strobe),
    .wdFall(wdFall), .atRstEnd(atRstEnd), .atDlyEnd(atDlyEnd),
    .atCycEnd(atCycEnd), .inHighHalf(inHighHalf)
  );

  sup_control u_ctl (
    .clk(clk), .rstAsyncN(rstAsyncN), .pwrGood(pwrGood), .wdFall(wdFall),
    .atRstEnd(atRstEnd), .atDlyEnd(atDlyEnd), .atCycEnd(atCycEnd),
    .inHighHalf(inHighHalf), .strobe(strobe), .wakeOut(wakeOut),
    .rstOutN(rstOutN)
  );
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int TICK = 4
) (
  input logic clk,
  input logic rstAsyncN,
  input logic pwrGood,
  input logic wakeOut,
  input logic rstOutN
);
  int highRun;

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN)   highRun <= 0;
    else if (wakeOut) highRun <= highRun + 1;
    else              highRun <= 0;
  end

  // R7
  a_r7_wake_gated: assert property (@(posedge clk) disable iff (!rstAsyncN)
    !rstOutN |-> !wakeOut);
  // R6
  a_r6_pg_forces_rst: assert property (@(posedge clk) disable iff (!rstAsyncN)
    !pwrGood |=> !rstOutN);
  // R6
  a_r6_release_needs_pg: assert property (@(posedge clk) disable iff (!rstAsyncN)
    $rose(rstOutN) |-> $past(pwrGood));
  // R8
  a_r8_no_wake_at_release: assert property (@(posedge clk) disable iff (!rstAsyncN)
    $rose(rstOutN) |-> !wakeOut);
  // R1
  a_r1_high_bounded: assert property (@(posedge clk) disable iff (!rstAsyncN)
    highRun <= 4 * TICK);
  // R8
  a_r8_wake_rise_in_run: assert property (@(posedge clk) disable iff (!rstAsyncN)
    $rose(wakeOut) |-> $past(rstOutN));
endmodule

bind wake_supervisor sup_checker #(.TICK(TICK)) u_chk (
  .clk(clk), .rstAsyncN(rstAsyncN), .pwrGood(pwrGood),
  .wakeOut(wakeOut), .rstOutN(rstOutN)
);

// File: tb/tb_wake_supervisor.sv
module tb_wake_supervisor;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rstAsyncN = 1'b0;
  logic pwrGood = 1'b0;
  logic wdRaw = 1'b1;
  logic wakeOut, rstOutN;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wake_supervisor #(.TICK(T)) dut (
    .clk(clk), .rstAsyncN(rstAsyncN), .pwrGood(pwrGood), .wdRaw(wdRaw),
    .wakeOut(wakeOut), .rstOutN(rstOutN)
  );

  // reference model built from the requirements
  int  mMode;   // 0 reset, 1 start-up delay, 2 running
  int  mAge;
  bit  mAns;
  bit  q1, q2, q3;

  function automatic int modeLen(int m);
    return (m == 0) ? T : (m == 1) ? 4 * T : 8 * T;
  endfunction

  function automatic bit expRst(int m);
    return m != 0;
  endfunction

  function automatic bit expWake(int m, int age, bit ans);
    return (m == 2) && (age < 4 * T) && !ans;
  endfunction

  always @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) begin
      mMode <= 0; mAge <= 0; mAns <= 0; q1 <= 1; q2 <= 1; q3 <= 1;
    end else begin
      bit fell;
      fell = q3 && !q2;
      q1 <= wdRaw; q2 <= q1; q3 <= q2;
      if (!pwrGood) begin
        mMode <= 0; mAge <= 0; mAns <= 0;
      end else if (mAge == modeLen(mMode) - 1) begin
        mAge <= 0;
        mAns <= 0;
        if (mMode == 2) mMode <= (mAns || fell) ? 2 : 0;
        else            mMode <= mMode + 1;
      end else begin
        mAge <= mAge + 1;
        if (mMode == 2 && fell) mAns <= 1;
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstAsyncN && !done) begin
      check("R6", rstOutN, expRst(mMode));
      check((mMode == 2) ? "R1" : "R7", wakeOut, expWake(mMode, mAge, mAns));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9", rstOutN, 1'b0);
    check("R9", wakeOut, 1'b0);
    rstAsyncN = 1'b1;
    @(negedge clk);

    // R6: release after TICK sampled high edges
    pwrGood = 1'b1;
    for (int i = 1; i <= T; i++) begin
      @(negedge clk);
      if (i == T - 1) check("R6", rstOutN, 1'b0);
      if (i == T)     check("R6", rstOutN, 1'b1);
    end

    // R8: first wake rise 4*TICK edges later
    for (int i = 1; i <= 4 * T; i++) begin
      @(negedge clk);
      check("R8", wakeOut, (i == 4 * T) ? 1'b1 : 1'b0);
    end

    // R3: answer early in high half
    wdRaw = 1'b0;
    @(negedge clk); check("R3", wakeOut, 1'b1);
    @(negedge clk); check("R3", wakeOut, 1'b1);
    @(negedge clk); check("R3", wakeOut, 1'b0);

    // R4: second edge, then hold low (R2: level is not an answer)
    wdRaw = 1'b1;
    repeat (2) @(negedge clk);
    wdRaw = 1'b0;
    repeat (3) @(negedge clk);
    check("R4", wakeOut, 1'b0);
    check("R4", rstOutN, 1'b1);

    // R5: next cycle is silent -> timeout reset of TICK cycles
    begin
      int guard = 0;
      int lowLen = 0;
      while (rstOutN && guard < 40 * T) begin @(negedge clk); guard++; end
      check("R2", rstOutN, 1'b0);
      while (!rstOutN && lowLen < 4 * T) begin
        check("R7", wakeOut, 1'b0);
        @(negedge clk); lowLen++;
      end
      vectors++;
      if (lowLen != T) begin
        miscompares++;
        $display("FAIL R5: actual %0d expected %0d", lowLen, T);
      end
    end
    wdRaw = 1'b1;

    // random stretches
    begin
      int rate = 0;
      int pgLow = 0;
      for (int c = 0; c < 15000; c++) begin
        @(negedge clk);
        if (c % 64 == 0) begin
          case ($urandom_range(0, 3))
            0: rate = 0;
            1: rate = 2;
            2: rate = 8;
            default: rate = 30;
          endcase
        end
        if ($urandom_range(0, 99) < rate) wdRaw = ~wdRaw;
        if (pgLow > 0) begin
          pgLow--;
          if (pgLow == 0) pwrGood = 1'b1;
        end else if ($urandom_range(0, 999) == 0) begin
          pwrGood = 1'b0;
          pgLow = int'($urandom_range(1, 6));
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule